// File: doc/BRIEF.md
# Link-Joint Handshake Stage

This block is a clocked model of one stage of a self-timed pipeline. The stage has two input links and one output link. A link is a register that holds a data word and a flag that says whether it is full or empty. A joint sits between the links and contains the combinational logic. Data crosses the joint only when every link the joint reads is full, every link it writes is empty, and an external `go` strobe is high. The `go` strobe stands in for the unpredictable gate and wire delays of a real self-timed circuit. A bench or a surrounding model can therefore drive `go` to try any order of events it needs.

The joint has three guarded actions: add, subtract and exclusive-or. A two-bit selector guards them, so no more than one of them can fire in any step. When an action fires, three things happen on the same clock edge. The result is written into the output link, the output link becomes full, and both input links become empty. An upstream producer loads the input links through fill strobes. A downstream consumer empties the output link through a drain strobe. A fill aimed at a full link does nothing, and so does a drain aimed at an empty link. Because a fill only loads an empty link and a fire only takes from full links, the two never act on the same link in the same cycle.

Top module: `lj_stage`

## Requirements
- R1: While `rst` is high at a rising edge, all three links become empty and their data words become zero.
- R2: A fill strobe aimed at an empty input link loads the supplied word and marks that link full at the next rising edge.
- R3: A fill strobe aimed at a full input link is ignored, and the word already stored is the one the next firing uses.
- R4: The joint fires only in a cycle where both input links are full, the output link is empty and `go` is high. On that edge the output link becomes full and both input links become empty.
- R5: When `go` is high but the fire condition is false, no link changes its flag or its data.
- R6: The selector `op` picks the action. Code 0 writes a+b, code 1 writes a-b and code 2 writes a^b, each taken modulo 2^W. Code 3 selects no action, and the joint never fires while it is selected.
- R7: A drain strobe empties a full output link and leaves its data word unchanged. A drain strobe on an empty output link has no effect.
- R8: No more than one guarded action fires in any cycle.
- R9: `fire` is high, combinationally, in exactly the cycles whose rising edge performs a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all links update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| go | input | 1 | Delay oracle; the joint may act only while it is high |
| op | input | 2 | Selector: 0 add, 1 subtract, 2 exclusive-or, 3 no action |
| fill_a | input | 1 | Producer strobe that loads input link A |
| fill_a_data | input | W | Word to load into link A |
| fill_b | input | 1 | Producer strobe that loads input link B |
| fill_b_data | input | W | Word to load into link B |
| drain | input | 1 | Consumer strobe that empties the output link |
| a_full | output | 1 | Input link A holds a word |
| b_full | output | 1 | Input link B holds a word |
| out_full | output | 1 | Output link holds a result |
| out_data | output | W | Data word stored in the output link |
| fire | output | 1 | The joint transfers at the coming edge |

## Verification
Some properties are checked by assertions on every cycle. A link goes from empty to full only through its own load strobe. A full link keeps its word until something empties it. No more than one action fires at a time. After a fire, the output link is full and both input links are empty. The output word stays stable in every cycle with no fire. The bench scenarios cover what depends on values and on the order of events: the arithmetic of each action, including wrap-around in subtraction, and that a refused fill keeps the word already stored. They also show that `go` is ignored when the condition is false or when code 3 is selected, and that a drain leaves the result word readable.

// File: rtl/lj_stage_pkg.sv
package lj_stage_pkg;
    typedef enum logic [1:0] {
        ACT_ADD  = 2'd0,
        ACT_SUB  = 2'd1,
        ACT_XOR  = 2'd2,
        ACT_NONE = 2'd3
    } act_e;

    localparam int NUM_ACT = 3;
endpackage

// File: rtl/lj_link.sv
module lj_link #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         set_i,
    input  logic [W-1:0] set_data_i,
    input  logic         clr_i,
    output logic         full_o,
    output logic [W-1:0] data_o
);
    typedef struct packed {
        logic         full;
        logic [W-1:0] data;
    } link_st_t;

    link_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i && !st_q.full) begin
            st_d.full = 1'b1;
            st_d.data = set_data_i;
        end else if (clr_i && st_q.full) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign full_o = st_q.full;
    assign data_o = st_q.data;

    // R2: an empty link turns full only through its load strobe
    assert_fill_only_R2: assert property (@(posedge clk) disable iff (rst)
        (!full_o && !set_i) |=> !full_o);

    // R3 / R7: a full link keeps its word while it is not emptied
    assert_hold_word_R3: assert property (@(posedge clk) disable iff (rst)
        (full_o && !clr_i) |=> (full_o && $stable(data_o)));

    // R7: the word stays in place when the link is emptied
    assert_clear_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (full_o && clr_i) |=> (!full_o && $stable(data_o)));
endmodule

// File: rtl/lj_joint.sv
module lj_joint
    import lj_stage_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_a_full_i,
    input  logic         in_b_full_i,
    input  logic         out_full_i,
    input  logic         go_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         fire_o,
    output logic [W-1:0] result_o
);
    logic               ready;
    logic [NUM_ACT-1:0] act_fire;
    logic [W-1:0]       act_res [NUM_ACT];

    assign ready = in_a_full_i && in_b_full_i && !out_full_i;

    for (genvar i = 0; i < NUM_ACT; i++) begin : g_act
        assign act_fire[i] = ready && go_i && (op_i == 2'(i));
        if (i == int'(ACT_ADD)) begin : g_add
            assign act_res[i] = a_i + b_i;
        end else if (i == int'(ACT_SUB)) begin : g_sub
            assign act_res[i] = a_i - b_i;
        end else begin : g_xor
            assign act_res[i] = a_i ^ b_i;
        end
    end

    always_comb begin
        result_o = '0;
        for (int k = 0; k < NUM_ACT; k++) begin
            if (act_fire[k]) result_o = act_res[k];
        end
    end

    assign fire_o = |act_fire;

    // R8: guarded actions are mutually exclusive
    assert_one_action_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(act_fire));

    // R6: the no-action code never produces a transfer
    assert_none_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (op_i == ACT_NONE) |-> !fire_o);
endmodule

// File: rtl/lj_stage.sv
module lj_stage
    import lj_stage_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [1:0]   op,
    input  logic         fill_a,
    input  logic [W-1:0] fill_a_data,
    input  logic         fill_b,
    input  logic [W-1:0] fill_b_data,
    input  logic         drain,
    output logic         a_full,
    output logic         b_full,
    output logic         out_full,
    output logic [W-1:0] out_data,
    output logic         fire
);
    logic [W-1:0] a_word, b_word, res_word;

    lj_link #(.W(W)) link_a_i (
        .clk(clk), .rst(rst), .set_i(fill_a), .set_data_i(fill_a_data),
        .clr_i(fire), .full_o(a_full), .data_o(a_word)
    );

    lj_link #(.W(W)) link_b_i (
        .clk(clk), .rst(rst), .set_i(fill_b), .set_data_i(fill_b_data),
        .clr_i(fire), .full_o(b_full), .data_o(b_word)
    );

    lj_joint #(.W(W)) joint_i (
        .clk(clk), .rst(rst),
        .in_a_full_i(a_full), .in_b_full_i(b_full), .out_full_i(out_full),
        .go_i(go), .op_i(op), .a_i(a_word), .b_i(b_word),
        .fire_o(fire), .result_o(res_word)
    );

    lj_link #(.W(W)) link_out_i (
        .clk(clk), .rst(rst), .set_i(fire), .set_data_i(res_word),
        .clr_i(drain), .full_o(out_full), .data_o(out_data)
    );

    // R4: after a transfer the output is full and both inputs are empty
    assert_fire_moves_R4: assert property (@(posedge clk) disable iff (rst)
        fire |=> (out_full && !a_full && !b_full));

    // R5: without a transfer the output word never changes
    assert_out_stable_R5: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(out_data));

    // R1: reset leaves every link empty
    assert_reset_empty_R1: assert property (@(posedge clk)
        rst |=> (!a_full && !b_full && !out_full && out_data == '0));
endmodule

// File: tb/lj_stage_tb.sv
`timescale 1ns/1ps
module lj_stage_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         go = 1'b0;
    logic [1:0]   op = 2'd0;
    logic         fill_a = 1'b0, fill_b = 1'b0, drain = 1'b0;
    logic [W-1:0] fill_a_data = '0, fill_b_data = '0;
    logic         a_full, b_full, out_full, fire;
    logic [W-1:0] out_data;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    lj_stage #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .go(go), .op(op),
        .fill_a(fill_a), .fill_a_data(fill_a_data),
        .fill_b(fill_b), .fill_b_data(fill_b_data),
        .drain(drain), .a_full(a_full), .b_full(b_full),
        .out_full(out_full), .out_data(out_data), .fire(fire)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1; go = 1'b0; fill_a = 0; fill_b = 0; drain = 0; op = 0;
        cyc(); cyc();
        rst = 1'b0;
    endtask

    task automatic load(input logic [W-1:0] av, input logic [W-1:0] bv);
        fill_a = 1; fill_a_data = av; fill_b = 1; fill_b_data = bv;
        cyc();
        fill_a = 0; fill_b = 0;
    endtask

    task automatic fire_op(input logic [1:0] code, input logic [W-1:0] exp, input string req);
        op = code; go = 1'b1;
        #0.5;
        check({req, " R9 fire strobe"}, fire, 1);
        cyc();
        go = 1'b0;
        check({req, " R4 out full"}, out_full, 1);
        check({req, " R4 inputs empty"}, {a_full, b_full}, 0);
        check({req, " R6 result"}, out_data, exp);
    endtask

    task automatic test_reset();
        do_reset();
        check("R1 a empty", a_full, 0);
        check("R1 b empty", b_full, 0);
        check("R1 out empty", out_full, 0);
        check("R1 out zero", out_data, 0);
    endtask

    task automatic test_add_drain();
        do_reset();
        fill_a = 1; fill_a_data = 8'h35;
        cyc();
        fill_a = 0;
        check("R2 a full after fill", a_full, 1);
        check("R2 b still empty", b_full, 0);
        fill_b = 1; fill_b_data = 8'h17;
        cyc();
        fill_b = 0;
        check("R2 b full after fill", b_full, 1);
        fire_op(2'd0, 8'h4C, "add");
        drain = 1;
        cyc();
        drain = 0;
        check("R7 drain empties", out_full, 0);
        check("R7 drain keeps word", out_data, 8'h4C);
    endtask

    task automatic test_sub_xor();
        do_reset();
        load(8'h10, 8'h20);
        fire_op(2'd1, 8'hF0, "sub wrap");
        drain = 1; cyc(); drain = 0;
        load(8'hAA, 8'h0F);
        fire_op(2'd2, 8'hA5, "xor");
    endtask

    task automatic test_fill_full_ignored();
        do_reset();
        load(8'h11, 8'h01);
        fill_a = 1; fill_a_data = 8'h99;
        cyc();
        fill_a = 0;
        check("R3 a still full", a_full, 1);
        fire_op(2'd0, 8'h12, "R3 old word used");
    endtask

    task automatic test_go_blocked();
        do_reset();
        fill_a = 1; fill_a_data = 8'h05;
        cyc();
        fill_a = 0;
        op = 2'd0; go = 1;
        #0.5;
        check("R5 no fire with b empty", fire, 0);
        cyc();
        go = 0;
        check("R5 a unchanged", a_full, 1);
        check("R5 out unchanged", out_full, 0);
        fill_b = 1; fill_b_data = 8'h03;
        cyc();
        fill_b = 0;
        #0.5;
        check("R4 no fire without go", fire, 0);
        cyc();
        check("R4 links hold without go", {a_full, b_full, out_full}, 3'b110);
        fire_op(2'd0, 8'h08, "first");
        load(8'h40, 8'h01);
        go = 1;
        #0.5;
        check("R5 no fire with out full", fire, 0);
        cyc();
        go = 0;
        check("R5 inputs stay full", {a_full, b_full}, 2'b11);
        check("R5 out word unchanged", out_data, 8'h08);
        drain = 1; op = 2'd1; go = 1;
        #0.5;
        check("R9 no fire while out full", fire, 0);
        cyc();
        drain = 0;
        check("R7 drained", out_full, 0);
        #0.5;
        check("R9 fire after drain", fire, 1);
        cyc();
        go = 0;
        check("R4 refire result", out_data, 8'h3F);
    endtask

    task automatic test_none_code();
        do_reset();
        load(8'h22, 8'h33);
        op = 2'd3; go = 1;
        #0.5;
        check("R6 none no fire", fire, 0);
        cyc();
        go = 0;
        check("R6 none links kept", {a_full, b_full, out_full}, 3'b110);
        check("R8 single action", out_data, 0);
        drain = 1;
        cyc();
        drain = 0;
        check("R7 drain on empty", out_full, 0);
        check("R7 drain on empty word", out_data, 0);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        test_reset();
        test_add_drain();
        test_sub_xor();
        test_fill_full_ignored();
        test_go_blocked();
        test_none_code();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule